// File: doc/BRIEF.md
# I2C Byte Engine with Acknowledge Control

This block is the bus-facing shift engine of an I2C controller. It generates SCL from the system clock and moves one byte per command over SDA. A single control register sets the SCL half-period through a 5-bit divider code and a standard/fast select. The same register decides whether a ninth acknowledge clock follows each byte and which level the engine puts on SDA during that clock when it is receiving. When the engine receives an address byte, it compares the upper seven bits with a programmed slave address and answers the acknowledge slot by itself.

Software reaches the engine through a small register port. The ports select a register with a 2-bit address. `0` is control: bit 7 enables the acknowledge clock, bit 6 is the level driven in that slot, bit 5 selects fast mode, and bits 4..0 hold the divider code. `1` is the slave address in bits 6..0. `2` is the transmit byte on write and the received byte on read. `3` is the command on write: bit 0 starts a byte, bit 1 selects receive, and bit 2 marks the byte as an address. On read, register `3` is status: bit 0 is busy and bit 1 is the acknowledge level. The lines are open-drain. An output-enable of 1 pulls the line low.

Top module: `i2c_byte_engine`

## Requirements
- R1: Every SCL high phase and every in-byte low phase lasts H system clocks. H is code*4 in standard mode (control bit 5 = 0) and code*2 in fast mode (bit 5 = 1).
- R2: A divider code below 3 is treated as 3 when H is computed.
- R3: Bytes are sent most significant bit first. The SDA enable changes only while the engine holds SCL low. The SDA line is sampled at each SCL release.
- R4: With control bit 7 = 0 a byte has 8 SCL clocks. With bit 7 = 1 it has 9. `byte_done` is a single-cycle pulse after the last clock, and busy is 0 while it is high.
- R5: When transmitting, the engine releases SDA during the ninth clock. The line level seen there is stored in `ack_status`, where 0 means acknowledged. Without a ninth clock, `ack_status` keeps its value.
- R6: When receiving a data byte, the engine pulls SDA low in the ninth clock if control bit 6 = 0 and leaves it released if bit 6 = 1. `rx_byte` holds the byte at `byte_done`.
- R7: When receiving an address byte, the engine pulls SDA low in the ninth clock only if bit 6 = 0 and received bits 7..1 equal the slave address bits 6..0. Otherwise it leaves SDA released.
- R8: A control write while busy that changes any bit other than bit 6 aborts the byte. From the next cycle SCL and SDA are released, busy is 0, and no `byte_done` follows.
- R9: A control write while busy that changes only bit 6 does not abort. The new bit 6 sets the acknowledge level of the current byte.
- R10: After reset both lines are released and `byte_done` and `ack_status` are 0. After a completed byte the engine keeps SCL held low and releases SDA one cycle after `byte_done`.
- R11: The control and slave-address registers read back the values written to them. Both reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| byte_done | output | 1 | One-cycle pulse when a byte completes |
| ack_status | output | 1 | SDA level seen in the last acknowledge clock |
| rx_byte | output | 8 | Last byte shifted in from SDA |

## Verification
The properties assume that no other device holds SCL low. They also assume that the far side changes SDA only while SCL is low, and that a start command is issued only while the engine is idle. The bench models the far device as a pull that the driver changes only after the engine has pulled SCL low. It issues commands only after the previous byte has completed or been aborted. It writes the control register mid-byte only inside a low phase.

// File: rtl/i2c_eng_pkg.sv
// Package: shared types and register map for the I2C byte engine.
// Assumes: control register layout is fixed by software (bit positions below).
package i2c_eng_pkg;

    // Control register, MSB first: ack clock enable, ack level, fast, divider code.
    typedef struct packed {
        logic       ack_clk_en;
        logic       ack_hi;
        logic       fast;
        logic [4:0] div_code;
    } ctl_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    localparam logic [1:0] A_CTL = 2'd0;
    localparam logic [1:0] A_SAD = 2'd1;
    localparam logic [1:0] A_DAT = 2'd2;
    localparam logic [1:0] A_CMD = 2'd3;

    localparam int CMD_GO  = 0;
    localparam int CMD_RX  = 1;
    localparam int CMD_ADR = 2;

endpackage

// File: rtl/i2c_eng_regs.sv
// Module: register file of the I2C byte engine.
// Holds control, slave address and transmit byte; decodes start and abort.
// Assumes: the engine reports busy so that start is ignored mid-byte.
module i2c_eng_regs
    import i2c_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       busy,
    input  logic       ack_status,
    input  logic [7:0] rx_byte,
    output ctl_t       ctl,
    output logic [6:0] slave_adr,
    output logic [7:0] tx_byte,
    output logic       go,
    output logic       go_rx,
    output logic       go_adr,
    output logic       abort
);

    localparam logic [7:0] KEEP_MASK = 8'hBF; // every bit but the ack level

    logic write_ctl;

    assign write_ctl = reg_we && (reg_addr == A_CTL);

    // Store software-written registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl       <= '0;
            slave_adr <= '0;
            tx_byte   <= '0;
        end else if (reg_we) begin
            case (reg_addr)
                A_CTL:   ctl       <= ctl_t'(reg_wdata);
                A_SAD:   slave_adr <= reg_wdata[6:0];
                A_DAT:   tx_byte   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Decode a start command, accepted only when idle.
    always_comb begin
        go     = reg_we && (reg_addr == A_CMD) && reg_wdata[CMD_GO] && !busy;
        go_rx  = reg_wdata[CMD_RX];
        go_adr = reg_wdata[CMD_ADR];
    end

    // A mid-byte control write that touches more than the ack level aborts.
    assign abort = write_ctl && busy &&
                   (((reg_wdata ^ 8'(ctl)) & KEEP_MASK) != 8'h00);

    // Combinational read mux.
    always_comb begin
        case (reg_addr)
            A_CTL:   reg_rdata = 8'(ctl);
            A_SAD:   reg_rdata = {1'b0, slave_adr};
            A_DAT:   reg_rdata = rx_byte;
            default: reg_rdata = {6'b0, ack_status, busy};
        endcase
    end

endmodule

// File: rtl/i2c_scl_timer.sv
// Module: SCL half-period timer.
// Reloads to H-1 on load and counts down; expired marks the last cycle of a phase.
// Assumes: STD_MUL >= FAST_MUL so CNT_W covers both modes.
module i2c_scl_timer #(
    parameter int STD_MUL  = 4,
    parameter int FAST_MUL = 2,
    parameter int MIN_CODE = 3,
    parameter int CNT_W    = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] div_code,
    input  logic       fast,
    input  logic       load,
    output logic       expired
);

    logic [4:0]       code_c;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] cnt;

    // Clamp the code and scale it by the selected mode.
    always_comb begin
        code_c = (int'(div_code) < MIN_CODE) ? 5'(MIN_CODE) : div_code;
        half   = fast ? CNT_W'(int'(code_c) * FAST_MUL)
                      : CNT_W'(int'(code_c) * STD_MUL);
    end

    // Down-counter for the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= half - CNT_W'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/i2c_bit_engine.sv
// Module: bit sequencer of the I2C byte engine.
// Walks low/high phases per bit, shifts MSB first, handles the ack slot.
// Assumes: no other device stretches SCL; start is only given while idle.
module i2c_bit_engine
    import i2c_eng_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic       go_rx,
    input  logic       go_adr,
    input  logic       abort,
    input  logic [7:0] tx_byte,
    input  logic [6:0] slave_adr,
    input  logic       ack_hi,
    input  logic       ack_clk_en,
    input  logic       sda_in,
    input  logic       tmr_expired,
    output logic       tmr_load,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       byte_done,
    output logic       ack_status,
    output logic       busy,
    output logic [7:0] rx_byte
);

    localparam logic [3:0] IDX_ACK  = 4'd8;
    localparam logic [3:0] IDX_LAST = 4'd7;

    phase_e     phase;
    logic [3:0] bit_idx;
    logic [7:0] tx_sh;
    logic [7:0] rx_sh;
    logic       rx_mode;
    logic       adr_mode;
    logic       last_bit;
    logic       low_end;
    logic       high_end;
    logic       adr_match;
    logic       ack_drive;

    // Phase-end and ack decisions.
    always_comb begin
        last_bit  = (bit_idx == (ack_clk_en ? IDX_ACK : IDX_LAST));
        low_end   = (phase == PH_LOW)  && tmr_expired;
        high_end  = (phase == PH_HIGH) && tmr_expired;
        adr_match = (rx_sh[7:1] == slave_adr);
        ack_drive = !ack_hi && (!adr_mode || adr_match);
        tmr_load  = !abort && (go || low_end || (high_end && !last_bit));
    end

    // Bit sequencer: phases, shifting, line enables and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            bit_idx    <= '0;
            tx_sh      <= '0;
            rx_sh      <= '0;
            rx_mode    <= 1'b0;
            adr_mode   <= 1'b0;
            scl_oe     <= 1'b0;
            sda_oe     <= 1'b0;
            byte_done  <= 1'b0;
            ack_status <= 1'b0;
        end else if (abort) begin
            phase     <= PH_IDLE;
            scl_oe    <= 1'b0;
            sda_oe    <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase    <= PH_LOW;
                        scl_oe   <= 1'b1;
                        bit_idx  <= '0;
                        tx_sh    <= tx_byte;
                        rx_mode  <= go_rx;
                        adr_mode <= go_adr;
                        sda_oe   <= !go_rx && !tx_byte[7];
                    end else begin
                        sda_oe   <= 1'b0;
                    end
                end
                PH_LOW: begin
                    if (tmr_expired) begin
                        phase  <= PH_HIGH;
                        scl_oe <= 1'b0;
                        if (bit_idx == IDX_ACK) begin
                            ack_status <= sda_in;
                        end else begin
                            rx_sh <= {rx_sh[6:0], sda_in};
                        end
                    end
                end
                PH_HIGH: begin
                    if (tmr_expired) begin
                        scl_oe <= 1'b1;
                        if (last_bit) begin
                            phase     <= PH_IDLE;
                            byte_done <= 1'b1;
                        end else begin
                            phase   <= PH_LOW;
                            bit_idx <= bit_idx + 4'd1;
                            tx_sh   <= {tx_sh[6:0], 1'b0};
                            if (bit_idx == IDX_LAST) begin
                                sda_oe <= rx_mode && ack_drive;
                            end else begin
                                sda_oe <= !rx_mode && !tx_sh[6];
                            end
                        end
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy    = (phase != PH_IDLE);
    assign rx_byte = rx_sh;

endmodule

// File: rtl/i2c_byte_engine.sv
// Module: top of the I2C byte engine.
// Joins register file, SCL timer and bit sequencer.
// Assumes: open-drain pads outside; an enable of 1 pulls the line low.
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int STD_MUL  = 4,
    parameter int FAST_MUL = 2,
    parameter int MIN_CODE = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       scl_oe,
    input  logic       sda_in,
    output logic       sda_oe,
    output logic       byte_done,
    output logic       ack_status,
    output logic [7:0] rx_byte
);

    localparam int MAX_CODE = 31;
    localparam int CNT_W    = $clog2(MAX_CODE * STD_MUL + 1);

    ctl_t       ctl_w;
    logic [6:0] sad_w;
    logic [7:0] txb_w;
    logic       go_w;
    logic       go_rx_w;
    logic       go_adr_w;
    logic       abort_w;
    logic       busy_w;
    logic       load_w;
    logic       exp_w;

    i2c_eng_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy_w),
        .ack_status (ack_status),
        .rx_byte    (rx_byte),
        .ctl        (ctl_w),
        .slave_adr  (sad_w),
        .tx_byte    (txb_w),
        .go         (go_w),
        .go_rx      (go_rx_w),
        .go_adr     (go_adr_w),
        .abort      (abort_w)
    );

    i2c_scl_timer #(
        .STD_MUL  (STD_MUL),
        .FAST_MUL (FAST_MUL),
        .MIN_CODE (MIN_CODE),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_code (ctl_w.div_code),
        .fast     (ctl_w.fast),
        .load     (load_w),
        .expired  (exp_w)
    );

    i2c_bit_engine u_bits (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go_w),
        .go_rx       (go_rx_w),
        .go_adr      (go_adr_w),
        .abort       (abort_w),
        .tx_byte     (txb_w),
        .slave_adr   (sad_w),
        .ack_hi      (ctl_w.ack_hi),
        .ack_clk_en  (ctl_w.ack_clk_en),
        .sda_in      (sda_in),
        .tmr_expired (exp_w),
        .tmr_load    (load_w),
        .scl_oe      (scl_oe),
        .sda_oe      (sda_oe),
        .byte_done   (byte_done),
        .ack_status  (ack_status),
        .busy        (busy_w),
        .rx_byte     (rx_byte)
    );

endmodule

// File: rtl/i2c_byte_engine_chk.sv
// Module: property checker for the I2C byte engine, bound to the top.
// Assumes: no external SCL stretching; start only while idle.
module i2c_byte_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_oe,
    input logic sda_oe,
    input logic byte_done,
    input logic busy,
    input logic abort,
    input logic go
);

    // SDA enable holds while SCL stays released (R3).
    p_sda_hold_scl_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && $past(!scl_oe) && !$past(abort)) |-> $stable(sda_oe));

    // A start pulls SCL low and makes the engine busy (R3).
    p_go_pulls_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (scl_oe && busy));

    // Completion is a single pulse with the engine idle (R4).
    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> !byte_done);

    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> !busy);

    // Abort releases both lines with no completion (R8).
    p_abort_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!scl_oe && !sda_oe && !busy && !byte_done));

    // Completion comes with SCL being pulled low again (R10).
    p_done_holds_scl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |-> (scl_oe && $past(!scl_oe)));

    // SDA is free once idle for more than a cycle (R10).
    p_idle_sda_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> !sda_oe);

endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .byte_done (byte_done),
    .busy      (busy_w),
    .abort     (abort_w),
    .go        (go_w)
);

// File: tb/i2c_byte_engine_tb.sv
// Scoreboard bench: driver tasks queue expected bytes, a monitor compares them.
module i2c_byte_engine_tb;
    import i2c_eng_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       scl_oe;
    logic       sda_oe;
    logic       sda_in;
    logic       byte_done;
    logic       ack_status;
    logic [7:0] rx_byte;
    logic       slv_pull = 1'b0;

    assign sda_in = ~(sda_oe | slv_pull);

    always #2 clk = ~clk;

    i2c_byte_engine u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_oe(scl_oe),
        .sda_in(sda_in), .sda_oe(sda_oe), .byte_done(byte_done),
        .ack_status(ack_status), .rx_byte(rx_byte)
    );

    typedef struct {
        bit       rx;
        bit [7:0] data;
        int       nbits;
        bit       ack_line;
        bit       ack_stat;
        string    tag;
    } exp_t;

    exp_t  q[$];
    int    checks = 0;
    int    fails = 0;
    int    exp_half = 0;
    string half_tag = "R1";
    bit    in_byte = 1'b0;
    bit    mon_clear = 1'b0;
    bit    last_ack = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step();
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        step();
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    // Monitor: captures bits at SCL release, times high phases, scores bytes.
    logic       prev_scl = 1'b0;
    logic       prev_sda = 1'b0;
    logic [8:0] cap = '0;
    int         nb = 0;
    int         hl = 0;
    bit         sda_bad = 1'b0;
    always @(negedge clk) begin : mon
        exp_t e;
        bit [7:0] got;
        if (rst_n) begin
            if (mon_clear) begin
                nb = 0; cap = '0; hl = 0; sda_bad = 1'b0;
            end else begin
                if (in_byte && !prev_scl && !scl_oe && (sda_oe != prev_sda))
                    sda_bad = 1'b1;
                if (prev_scl && !scl_oe) begin
                    cap = {cap[7:0], sda_in};
                    nb++;
                    hl = 1;
                end else if (!prev_scl && !scl_oe && nb > 0) begin
                    hl++;
                end else if (!prev_scl && scl_oe && nb > 0) begin
                    chk(hl == exp_half, half_tag, "scl high length", hl, exp_half);
                end
                if (byte_done) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R8", "done without pending byte", 1, 0);
                    end else begin
                        e = q.pop_front();
                        chk(nb == e.nbits, "R4", "scl clocks per byte", nb, e.nbits);
                        got = (e.nbits == 9) ? cap[8:1] : cap[7:0];
                        chk(got == e.data, e.tag, "bits on sda msb first", got, e.data);
                        if (e.nbits == 9)
                            chk(cap[0] == e.ack_line, e.tag, "ack slot line", cap[0], e.ack_line);
                        chk(ack_status == e.ack_stat, "R5", "ack_status", ack_status, e.ack_stat);
                        if (e.rx)
                            chk(rx_byte == e.data, "R6", "rx_byte", rx_byte, e.data);
                        chk(!sda_bad, "R3", "sda moved while scl high", sda_bad, 0);
                    end
                    nb = 0; cap = '0; sda_bad = 1'b0;
                end
            end
            prev_scl = scl_oe;
            prev_sda = sda_oe;
        end
    end

    // Driver: queues the expected result and plays the far device.
    task automatic run_byte(input bit rx, input bit adr, input bit [7:0] data,
                            input bit slave_ack, input int nbits,
                            input bit ack_line, input bit ack_stat, input string tag,
                            input bit mid_en, input bit [7:0] mid_val,
                            input bit abort_exp);
        exp_t e;
        logic [7:0] v;
        if (!rx) wr(A_DAT, data);
        if (!abort_exp) begin
            e.rx = rx; e.data = data; e.nbits = nbits;
            e.ack_line = ack_line; e.ack_stat = ack_stat; e.tag = tag;
            q.push_back(e);
        end
        in_byte = 1'b1;
        wr(A_CMD, {5'b0, adr, rx, 1'b1});
        for (int i = 0; i < nbits; i++) begin
            while (scl_oe !== 1'b1) step();
            if (rx) slv_pull = (i < 8) ? ~data[7-i] : 1'b0;
            else    slv_pull = (i == 8) ? slave_ack : 1'b0;
            if (mid_en && i == 3) begin
                wr(A_CTL, mid_val);
                if (abort_exp) begin
                    chk(!scl_oe && !sda_oe, "R8", "lines after abort",
                        {scl_oe, sda_oe}, 0);
                    slv_pull = 1'b0;
                    mon_clear = 1'b1;
                    step();
                    mon_clear = 1'b0;
                    in_byte = 1'b0;
                    repeat (300) step();
                    rd(A_CMD, v);
                    chk(v[0] == 1'b0, "R8", "busy after abort", v[0], 0);
                    chk(scl_oe == 1'b0, "R8", "scl stays released", scl_oe, 0);
                    return;
                end
            end
            while (scl_oe !== 1'b0) step();
        end
        while (scl_oe !== 1'b1) step();
        step();
        slv_pull = 1'b0;
        chk(scl_oe == 1'b1 && sda_oe == 1'b0, "R10", "lines after byte",
            {scl_oe, sda_oe}, 2);
        in_byte = 1'b0;
        repeat (3) step();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 / R11: reset state
        chk(scl_oe == 0 && sda_oe == 0, "R10", "lines at reset", {scl_oe, sda_oe}, 0);
        chk(byte_done == 0 && ack_status == 0, "R10", "flags at reset",
            {byte_done, ack_status}, 0);
        rd(A_CTL, v);
        chk(v == 8'h00, "R11", "ctl reset value", v, 0);
        wr(A_SAD, 8'h52);
        rd(A_SAD, v);
        chk(v == 8'h52, "R11", "slave address readback", v, 8'h52);
        wr(A_CTL, 8'h85);
        rd(A_CTL, v);
        chk(v == 8'h85, "R11", "ctl readback", v, 8'h85);

        // R1 R3 R5: standard mode, code 5 -> H=20, transmit, acknowledged
        exp_half = 20; half_tag = "R1";
        run_byte(0, 0, 8'hA5, 1, 9, 0, 0, "R3", 0, 8'h00, 0);
        last_ack = 1'b0;

        // R1 R4 R5: fast code 5 -> H=10, no ack clock, ack_status kept
        wr(A_CTL, 8'h25); exp_half = 10;
        run_byte(0, 0, 8'h3C, 0, 8, 0, last_ack, "R4", 0, 8'h00, 0);

        // R2 R5: fast code 1 clamps to 3 -> H=6, not acknowledged
        wr(A_CTL, 8'hA1); exp_half = 6; half_tag = "R2";
        run_byte(0, 0, 8'h81, 0, 9, 1, 1, "R5", 0, 8'h00, 0);

        // R2 R6: standard code 2 clamps -> H=12, receive data, ack driven low
        wr(A_CTL, 8'h82); exp_half = 12;
        run_byte(1, 0, 8'h5A, 0, 9, 0, 0, "R6", 0, 8'h00, 0);

        // R6: ack level 1 leaves ack slot high
        wr(A_CTL, 8'hC2); half_tag = "R1";
        run_byte(1, 0, 8'hC3, 0, 9, 1, 1, "R6", 0, 8'h00, 0);

        // R7: address match / mismatch / ack level 1 / read bit set
        wr(A_CTL, 8'h83); exp_half = 12;
        run_byte(1, 1, 8'hA4, 0, 9, 0, 0, "R7", 0, 8'h00, 0);
        run_byte(1, 1, 8'hA6, 0, 9, 1, 1, "R7", 0, 8'h00, 0);
        run_byte(1, 1, 8'hA5, 0, 9, 0, 0, "R7", 0, 8'h00, 0);
        wr(A_CTL, 8'hC3);
        run_byte(1, 1, 8'hA4, 0, 9, 1, 1, "R7", 0, 8'h00, 0);

        // R9: ack level changed mid-byte, no abort, new level used
        run_byte(1, 0, 8'h77, 0, 9, 0, 0, "R9", 1, 8'h83, 0);

        // R8: divider change mid-byte aborts, then a clean byte follows
        run_byte(0, 0, 8'h0F, 0, 9, 0, 0, "R8", 1, 8'h86, 1);
        exp_half = 24;
        run_byte(0, 0, 8'h96, 1, 9, 0, 0, "R8", 0, 8'h00, 0);

        chk(q.size() == 0, "R4", "pending bytes left", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule